// File: doc/BRIEF.md
# Key-Unlocked RAM Erase Sequencer

This block clears an on-chip RAM region by writing zero into every word, one word per clock, from the lowest address to the highest. Software starts a clear through a small register port. The start bit is guarded: it can only be set after a two-byte unlock code has been written to an 8-bit key register, with the bytes in the right order.

A control/status register holds a start bit and a read-only busy bit. The start bit clears itself when the last word has been written. A one-cycle done pulse follows. Each accepted start locks the key again, so every clear needs a fresh unlock.

The RAM array, the bus adapters and any per-page protection belong to the surrounding logic.

Top module: `ram_wipe_ctrl`

## Requirements
- R1: After reset, the control register at offset 0x18 reads 0. The key register at offset 0x24 reads 0. `ram_we` and `wipe_done` are low.
- R2: Two consecutive key writes, 0xCA and then 0x53 (bits 7:0 of the key register), unlock the block. A later write of 1 to bit 0 of the control register is accepted, and busy (bit 1) and start (bit 0) read 1 in the next cycle.
- R3: While the block is locked, a write of 1 to the start bit is ignored. Both status bits stay 0 and `ram_we` stays low.
- R4: Some key writes break the unlock sequence: 0x53 with no 0xCA just before it, or any value other than 0xCA and 0x53. Such a write returns the block to locked. A write of 0xCA always restarts the sequence at its first step.
- R5: In the cycle after an accepted start, `ram_we` goes high with `ram_addr` = 0 and `ram_wdata` = 0. The address rises by one each cycle for exactly DEPTH cycles and ends at DEPTH-1.
- R6: Start and busy read 1 for the whole sweep and fall together in the cycle after the last word. `wipe_done` is high for exactly that one cycle.
- R7: An accepted start relocks the key. A second start write after the sweep, with no new unlock, is ignored.
- R8: Start-bit writes are ignored while busy. Writing 0 does not abort the sweep, and writing 1 does not restart it. This includes a write that lands in the last sweep cycle. A rejected start write leaves the key state unchanged, so a key unlocked during a sweep is still usable after it.
- R9: The key register always reads 0.
- R10: Only key-register writes count toward the unlock sequence. Writes to other offsets between the two key bytes do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data for `reg_addr` (combinational) |
| ram_addr | output | RAM_AW | RAM word address during the sweep |
| ram_wdata | output | DATA_W | RAM write data (always zero) |
| ram_we | output | 1 | RAM write strobe, high while sweeping |
| wipe_done | output | 1 | One-cycle pulse after the last word is written |

## Verification
The sweep's final word and a new start request can fall in the same clock edge. At that edge the busy flag is falling and a start write is being judged against it.

The bench opens the key during a running sweep, so that only the busy rule can block a start. It then drives a start write in the exact cycle where `ram_addr` equals DEPTH-1. The check has three parts:
- the sweep writes exactly DEPTH words;
- done pulses and both status bits are 0 in the following cycles, so no restart happened;
- a later start still succeeds, which shows the rejected write did not consume the unlock.

// File: rtl/ram_wipe_pkg.sv
package ram_wipe_pkg;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_phase_e;

endpackage

// File: rtl/wipe_key_gate.sv
module wipe_key_gate
    import ram_wipe_pkg::*;
#(
    parameter int unsigned KEY_W      = 8,
    parameter int unsigned KEY_FIRST  = 'hCA,
    parameter int unsigned KEY_SECOND = 'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             consume,
    output logic             unlocked
);

    localparam logic [KEY_W-1:0] FIRST_V  = KEY_W'(KEY_FIRST);
    localparam logic [KEY_W-1:0] SECOND_V = KEY_W'(KEY_SECOND);

    typedef struct packed {
        key_phase_e phase;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (consume) begin
            gate_d.phase = KEY_LOCKED;
        end else if (key_wr) begin
            if (key_val == FIRST_V) begin
                gate_d.phase = KEY_HALF;
            end else if (gate_q.phase == KEY_HALF && key_val == SECOND_V) begin
                gate_d.phase = KEY_OPEN;
            end else begin
                gate_d.phase = KEY_LOCKED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '{phase: KEY_LOCKED};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign unlocked = (gate_q.phase == KEY_OPEN);

endmodule

// File: rtl/wipe_sweep.sv
module wipe_sweep #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    output logic              busy,
    output logic              finishing,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic              done
);

    localparam logic [RAM_AW-1:0] LAST = RAM_AW'(DEPTH - 1);

    typedef struct packed {
        logic              busy;
        logic [RAM_AW-1:0] addr;
        logic              done;
    } sweep_t;

    sweep_t sw_d, sw_q;

    always_comb begin
        sw_d      = sw_q;
        sw_d.done = 1'b0;
        if (sw_q.busy) begin
            if (sw_q.addr == LAST) begin
                sw_d.busy = 1'b0;
                sw_d.addr = '0;
                sw_d.done = 1'b1;
            end else begin
                sw_d.addr = sw_q.addr + 1'b1;
            end
        end else if (launch) begin
            sw_d.busy = 1'b1;
            sw_d.addr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '{busy: 1'b0, addr: '0, done: 1'b0};
        end else begin
            sw_q <= sw_d;
        end
    end

    assign busy      = sw_q.busy;
    assign finishing = sw_q.busy && (sw_q.addr == LAST);
    assign ram_addr  = sw_q.addr;
    assign ram_we    = sw_q.busy;
    assign done      = sw_q.done;

endmodule

// File: rtl/ram_wipe_ctrl.sv
module ram_wipe_ctrl #(
    parameter int unsigned DEPTH      = 256,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned REG_AW     = 8,
    parameter int unsigned REG_DW     = 32,
    parameter int unsigned CTRL_OFF   = 'h18,
    parameter int unsigned KEY_OFF    = 'h24,
    parameter int unsigned KEY_FIRST  = 'hCA,
    parameter int unsigned KEY_SECOND = 'h53,
    parameter int unsigned RAM_AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              wipe_done
);

    localparam int unsigned KEY_W = 8;

    typedef struct packed {
        logic start;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic ctrl_sel, key_sel, key_wr, launch;
    logic key_open, busy, finishing, start_bit;

    assign ctrl_sel = (reg_addr == REG_AW'(CTRL_OFF));
    assign key_sel  = (reg_addr == REG_AW'(KEY_OFF));
    assign key_wr   = reg_we && key_sel;
    assign launch   = reg_we && ctrl_sel && reg_wdata[0] && key_open && !busy;

    wipe_key_gate #(
        .KEY_W     (KEY_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (reg_wdata[KEY_W-1:0]),
        .consume (launch),
        .unlocked(key_open)
    );

    wipe_sweep #(
        .DEPTH (DEPTH),
        .RAM_AW(RAM_AW)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .busy     (busy),
        .finishing(finishing),
        .ram_addr (ram_addr),
        .ram_we   (ram_we),
        .done     (wipe_done)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (launch) begin
            ctrl_d.start = 1'b1;
        end else if (finishing) begin
            ctrl_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{start: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign start_bit = ctrl_q.start;

    always_comb begin
        reg_rdata = '0;
        if (ctrl_sel) begin
            reg_rdata[0] = start_bit;
            reg_rdata[1] = busy;
        end
    end

    assign ram_wdata = '0;

endmodule

// File: rtl/ram_wipe_chk.sv
module ram_wipe_chk #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned RAM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              wipe_done,
    input logic              busy,
    input logic              start_bit,
    input logic              key_open
);

    localparam logic [RAM_AW-1:0] LAST = RAM_AW'(DEPTH - 1);

    // R5
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> ram_addr == '0);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr != LAST) |=> (ram_we && ram_addr == RAM_AW'($past(ram_addr) + 1'b1)));

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == LAST) |=> (wipe_done && !ram_we));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_done |=> !wipe_done);

    // R6
    start_busy_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit == busy);

    // R2
    launch_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(key_open));

    // R7
    launch_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !key_open);

endmodule

bind ram_wipe_ctrl ram_wipe_chk #(
    .DEPTH (DEPTH),
    .RAM_AW(RAM_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .wipe_done(wipe_done),
    .busy     (busy),
    .start_bit(start_bit),
    .key_open (key_open)
);

// File: tb/ram_wipe_ctrl_bench.sv
`timescale 1ns/1ps
module ram_wipe_ctrl_bench;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam logic [7:0] CTRL = 8'h18;
    localparam logic [7:0] KEY  = 8'h24;

    // vector: [26:25] key count, [24:17] k0, [16:9] k1, [8:1] k2, [0] start expected
    localparam logic [26:0] VECS [8] = '{
        {2'd2, 8'hCA, 8'h53, 8'h00, 1'b1},
        {2'd2, 8'h53, 8'hCA, 8'h00, 1'b0},
        {2'd3, 8'hCA, 8'h11, 8'h53, 1'b0},
        {2'd3, 8'hCA, 8'hCA, 8'h53, 1'b1},
        {2'd3, 8'h11, 8'hCA, 8'h53, 1'b1},
        {2'd3, 8'hCA, 8'h53, 8'h00, 1'b0},
        {2'd3, 8'hCA, 8'h53, 8'hCA, 1'b0},
        {2'd1, 8'hCA, 8'h00, 8'h00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [AW-1:0] ram_addr;
    logic [31:0] ram_wdata;
    logic        ram_we;
    logic        wipe_done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ram_wipe_ctrl #(.DEPTH(DEPTH)) u_ram_wipe_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata),
        .ram_we   (ram_we),
        .wipe_done(wipe_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_addr  = CTRL;
    endtask

    // entered at the negedge after an accepted start write
    task automatic sweep_check(input string req);
        logic bad = 1'b0;
        logic [31:0] bad_act = '0;
        logic [31:0] bad_exp = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!bad && (ram_we !== 1'b1 || ram_addr !== AW'(i) || ram_wdata !== 32'd0
                         || reg_rdata !== 32'd3)) begin
                bad     = 1'b1;
                bad_act = {reg_rdata[7:0], 7'd0, ram_we, 12'd0, ram_addr};
                bad_exp = {8'd3, 7'd0, 1'b1, 12'd0, AW'(i)};
            end
            @(negedge clk);
        end
        chk({req, " R5 sweep words"}, bad_act, bad_exp);
        chk({req, " R6 done pulse"}, {31'd0, wipe_done}, 32'd1);
        chk({req, " R6 status clear"}, reg_rdata, 32'd0);
        @(negedge clk);
        chk({req, " R6 done one cycle"}, {31'd0, wipe_done}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = CTRL;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl", reg_rdata, 32'd0);
        chk("R1 ram_we", {31'd0, ram_we}, 32'd0);
        chk("R1 done", {31'd0, wipe_done}, 32'd0);
        reg_addr = KEY;
        #1;
        chk("R1 key", reg_rdata, 32'd0);
        reg_addr = CTRL;

        // key sequence table: R2 R3 R4
        foreach (VECS[v]) begin
            wr(KEY, 32'h0);
            for (int k = 0; k < int'(VECS[v][26:25]); k++) begin
                wr(KEY, {24'd0, VECS[v][24 - 8*k -: 8]});
            end
            wr(CTRL, 32'd1);
            if (VECS[v][0]) begin
                chk($sformatf("R2 vec%0d start", v), reg_rdata, 32'd3);
                sweep_check($sformatf("vec%0d", v));
            end else begin
                chk($sformatf("R3 R4 vec%0d ignored", v), reg_rdata, 32'd0);
                chk($sformatf("R3 vec%0d no ram_we", v), {31'd0, ram_we}, 32'd0);
            end
        end

        // R7 relock after start
        wr(KEY, 32'hCA);
        wr(KEY, 32'h53);
        wr(CTRL, 32'd1);
        sweep_check("R7 first");
        wr(CTRL, 32'd1);
        chk("R7 second start ignored", reg_rdata, 32'd0);

        // R9 key reads zero
        wr(KEY, 32'hCA);
        reg_addr = KEY;
        #1;
        chk("R9 key read after CA", reg_rdata, 32'd0);
        wr(KEY, 32'h53);
        reg_addr = KEY;
        #1;
        chk("R9 key read after 53", reg_rdata, 32'd0);
        reg_addr = CTRL;
        wr(KEY, 32'h0);

        // R10 other-offset writes between key bytes
        wr(KEY, 32'hCA);
        wr(8'h00, 32'h53);
        wr(8'h1C, 32'hFF);
        wr(KEY, 32'h53);
        wr(CTRL, 32'd1);
        chk("R10 start after interleaved writes", reg_rdata, 32'd3);
        sweep_check("R10");

        // R8 writes during sweep, start in the last sweep cycle
        wr(KEY, 32'hCA);
        wr(KEY, 32'h53);
        wr(CTRL, 32'd1);
        begin
            int we_cycles = 0;
            for (int c = 0; c < DEPTH; c++) begin
                if (ram_we) we_cycles++;
                reg_we   = 1'b0;
                reg_addr = CTRL;
                if (ram_addr == AW'(2)) begin
                    reg_addr = KEY; reg_wdata = 32'hCA; reg_we = 1'b1;
                end else if (ram_addr == AW'(3)) begin
                    reg_addr = KEY; reg_wdata = 32'h53; reg_we = 1'b1;
                end else if (ram_addr == AW'(5)) begin
                    reg_wdata = 32'd0; reg_we = 1'b1;
                end else if (ram_addr == AW'(DEPTH - 1)) begin
                    reg_wdata = 32'd1; reg_we = 1'b1;
                end
                @(negedge clk);
            end
            reg_we   = 1'b0;
            reg_addr = CTRL;
            chk("R8 sweep length unchanged", we_cycles, DEPTH);
        end
        chk("R8 done at end", {31'd0, wipe_done}, 32'd1);
        chk("R8 last-cycle start ignored", reg_rdata, 32'd0);
        @(negedge clk);
        chk("R8 no restart", {30'd0, reg_rdata[1], ram_we}, 32'd0);
        wr(CTRL, 32'd1);
        chk("R8 key kept after rejected start", reg_rdata, 32'd3);
        sweep_check("R8 post");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule